// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between an execute stage and a 32-bit word-wide data memory. For every memory request it forms the effective address by adding a sign-extended 16-bit displacement to a base value. It then drives the memory with a word address, a per-lane byte-enable mask and, for stores, write data whose source bytes have been moved into the lanes they address. Lanes are ordered little-endian: the least significant byte of a word lives at the lowest byte address.

On loads the memory answers one cycle after the read strobe. The unit remembers the size, signedness and lane offset of the pending read. When the word comes back it picks out the addressed byte or halfword and widens it to 32 bits, with sign or zero fill chosen by the opcode. A halfword or word request that does not sit on its natural boundary raises a flag for that cycle and never reaches the memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, so a displacement of 0xFFF8 subtracts 8. `mem_addr` carries effective-address bits [31:2].
- R2: On an aligned access, `mem_be` bit k is set for each byte lane k the access covers. A byte access at offset n (effective-address bits [1:0]) gives a one-hot mask with bit n set. A halfword access gives 0011 at offset 0 and 1100 at offset 2. A word access gives 1111. When no access is made, `mem_be` is 0000.
- R3: On a store, the low byte (byte store) or low halfword (halfword store) of `req_store_data` appears in the addressed lanes of `mem_wdata`, and every lane outside the mask is zero. A word store passes the data through unchanged. Store opcodes are 0x28 for byte, 0x29 for halfword and 0x2B for word.
- R4: A halfword access with effective-address bit 0 set, or a word access with bits [1:0] not zero, raises `misaligned` in the same cycle. Neither `mem_wr_en` nor `mem_rd_en` rises for it, and memory contents are unchanged afterwards. Byte accesses are never misaligned.
- R5: Each `mem_rd_en` is followed on the next cycle by `load_valid` high, with the result on `load_data`. In every other cycle `load_valid` is low and `load_data` is zero.
- R6: The signed loads, opcode 0x20 for byte and 0x21 for halfword, replicate bit 7 or bit 15 of the loaded item into all higher bits of `load_data`.
- R7: The unsigned loads, opcode 0x24 for byte and 0x25 for halfword, fill the upper bits with zeros. The word load, opcode 0x23, returns the full word.
- R8: Loads select the returned lanes little-endian: a byte load at offset n returns bits [8n+7:8n], and a halfword load at offset 2 returns bits [31:16].
- R9: When `req_valid` is high with an opcode outside the eight listed, no read or write is issued, `misaligned` stays low and no load result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory request is presented this cycle |
| req_op | input | 6 | Primary opcode of the request |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_store_data | input | 32 | Register value to store |
| mem_addr | output | 30 | Word address to the memory |
| mem_wr_en | output | 1 | Write strobe |
| mem_rd_en | output | 1 | Read strobe |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Word returned one cycle after a read strobe |
| misaligned | output | 1 | Request violates natural alignment |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |

## Verification
The bench exercises all four byte offsets, both halfword positions and the word case. A reversed lane order or an off-by-one in the steering shows up as a wrong byte returned or written. Loads of items whose top bit is set, such as 0x85 and 0x8001, separate signed from unsigned handling, so a swapped extension produces a wrong upper half. A negative displacement catches a zero-extended offset, which would land the access 64 KiB away. Misaligned halfword and word requests are each followed by a read of the targeted word: a design that leaked the write would change that word, and one that leaked the read would raise `load_valid`.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

   typedef enum logic [5:0] {
      OP_LB  = 6'h20,
      OP_LH  = 6'h21,
      OP_LW  = 6'h23,
      OP_LBU = 6'h24,
      OP_LHU = 6'h25,
      OP_SB  = 6'h28,
      OP_SH  = 6'h29,
      OP_SW  = 6'h2B
   } mem_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic      is_load;
      logic      is_store;
      acc_size_e size;
      logic      sign_ext;
   } acc_ctl_t;

   function automatic acc_ctl_t lsu_decode(input logic [5:0] op);
      acc_ctl_t c;
      c = '{is_load: 1'b0, is_store: 1'b0, size: SZ_BYTE, sign_ext: 1'b0};
      case (op)
         OP_LB:  c = '{1'b1, 1'b0, SZ_BYTE, 1'b1};
         OP_LBU: c = '{1'b1, 1'b0, SZ_BYTE, 1'b0};
         OP_LH:  c = '{1'b1, 1'b0, SZ_HALF, 1'b1};
         OP_LHU: c = '{1'b1, 1'b0, SZ_HALF, 1'b0};
         OP_LW:  c = '{1'b1, 1'b0, SZ_WORD, 1'b0};
         OP_SB:  c = '{1'b0, 1'b1, SZ_BYTE, 1'b0};
         OP_SH:  c = '{1'b0, 1'b1, SZ_HALF, 1'b0};
         OP_SW:  c = '{1'b0, 1'b1, SZ_WORD, 1'b0};
         default: ;
      endcase
      return c;
   endfunction

   function automatic int lsu_nbytes(input acc_size_e sz);
      return 1 << int'(sz);
   endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [5:0]        req_op,
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] eff_addr,
   output acc_ctl_t          ctl,
   output logic              access_ok,
   output logic              misaligned,
   output logic [LANES-1:0]  be
);
   localparam int LB = $clog2(LANES);

   logic [ADDR_W-1:0] off_ext;
   logic              memop;
   logic [LB-1:0]     lane_off;
   logic [LB-1:0]     size_mask;

   assign off_ext  = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
   assign eff_addr = base + off_ext;
   assign ctl      = lsu_decode(req_op);
   assign memop    = req_valid && (ctl.is_load || ctl.is_store);
   assign lane_off = eff_addr[LB-1:0];

   always_comb size_mask = LB'(lsu_nbytes(ctl.size) - 1);

   assign misaligned = memop && ((lane_off & size_mask) != '0);
   assign access_ok  = memop && !misaligned;

   for (genvar k = 0; k < LANES; k++) begin : g_be
      assign be[k] = access_ok && (k >= int'(lane_off))
                     && ((k - int'(lane_off)) < lsu_nbytes(ctl.size));
   end

   AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (be == '0) && !access_ok);                       // R4
   AST_BYTE_NEVER_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ctl.size == SZ_BYTE) |-> !misaligned);             // R4
   AST_BYTE_BE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (access_ok && ctl.size == SZ_BYTE) |-> ($countones(be) == 1));   // R2
   AST_WORD_BE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (access_ok && ctl.size == SZ_WORD) |-> (&be));                   // R2
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic [DATA_W-1:0]        store_data,
   input  acc_size_e                size,
   input  logic [$clog2(LANES)-1:0] lane_off,
   output logic [DATA_W-1:0]        wdata
);
   localparam int LB = $clog2(LANES);

   logic [7:0] src_b [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_src
      assign src_b[k] = store_data[8*k +: 8];
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      int rel;
      always_comb begin
         rel = k - int'(lane_off);
         if (rel >= 0 && rel < lsu_nbytes(size))
            wdata[8*k +: 8] = src_b[rel[LB-1:0]];
         else
            wdata[8*k +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_lane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_fire,
   input  acc_size_e                size,
   input  logic                     sign_ext,
   input  logic [$clog2(LANES)-1:0] lane_off,
   input  logic [DATA_W-1:0]        rdata,
   output logic                     load_valid,
   output logic [DATA_W-1:0]        load_data
);
   localparam int LB = $clog2(LANES);

   logic          pend_v;
   acc_size_e     pend_size;
   logic          pend_sign;
   logic [LB-1:0] pend_off;
   logic [7:0]    rbyte [LANES];
   logic [7:0]    sel_b;
   logic [15:0]   sel_h;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_size <= SZ_BYTE;
         pend_sign <= 1'b0;
         pend_off  <= '0;
      end else begin
         pend_v <= rd_fire;
         if (rd_fire) begin
            pend_size <= size;
            pend_sign <= sign_ext;
            pend_off  <= lane_off;
         end
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_rb
      assign rbyte[k] = rdata[8*k +: 8];
   end

   assign sel_b = rbyte[pend_off];
   assign sel_h = {rbyte[pend_off + LB'(1)], rbyte[pend_off]};

   always_comb begin
      load_data = '0;
      if (pend_v) begin
         case (pend_size)
            SZ_BYTE: load_data = {{(DATA_W-8){pend_sign & sel_b[7]}}, sel_b};
            SZ_HALF: load_data = {{(DATA_W-16){pend_sign & sel_h[15]}}, sel_h};
            default: load_data = rdata;
         endcase
      end
   end

   assign load_valid = pend_v;

   AST_UNSIGNED_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !pend_sign && pend_size == SZ_BYTE)
         |-> (load_data[DATA_W-1:8] == '0));                            // R7
   AST_SIGNED_HALF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && pend_sign && pend_size == SZ_HALF)
         |-> (load_data[DATA_W-1:16] == {(DATA_W-16){rdata[8*int'(pend_off)+15]}})); // R6
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_lane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int DATA_W = 32,
   localparam int LANES   = DATA_W / 8,
   localparam int LB      = $clog2(LANES),
   localparam int WADDR_W = ADDR_W - LB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [5:0]         req_op,
   input  logic [ADDR_W-1:0]  req_base,
   input  logic [OFF_W-1:0]   req_offset,
   input  logic [DATA_W-1:0]  req_store_data,
   output logic [WADDR_W-1:0] mem_addr,
   output logic               mem_wr_en,
   output logic               mem_rd_en,
   output logic [LANES-1:0]   mem_be,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               misaligned,
   output logic               load_valid,
   output logic [DATA_W-1:0]  load_data
);
   if (DATA_W != 32) begin : g_chk_data
      $error("lsu_lane_unit: opcode set assumes a 32-bit data word");
   end
   if (OFF_W >= ADDR_W) begin : g_chk_off
      $error("lsu_lane_unit: offset must be narrower than the address");
   end

   logic [ADDR_W-1:0] eff_addr;
   acc_ctl_t          ctl;
   logic              access_ok;

   lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .base       (req_base),
      .offset     (req_offset),
      .eff_addr   (eff_addr),
      .ctl        (ctl),
      .access_ok  (access_ok),
      .misaligned (misaligned),
      .be         (mem_be)
   );

   lsu_store_steer #(.DATA_W(DATA_W), .LANES(LANES)) u_steer (
      .store_data (req_store_data),
      .size       (ctl.size),
      .lane_off   (eff_addr[LB-1:0]),
      .wdata      (mem_wdata)
   );

   assign mem_addr  = eff_addr[ADDR_W-1:LB];
   assign mem_wr_en = access_ok && ctl.is_store;
   assign mem_rd_en = access_ok && ctl.is_load;

   lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES)) u_load (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_fire    (mem_rd_en),
      .size       (ctl.size),
      .sign_ext   (ctl.sign_ext),
      .lane_off   (eff_addr[LB-1:0]),
      .rdata      (mem_rdata),
      .load_valid (load_valid),
      .load_data  (load_data)
   );

   AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en && mem_rd_en));                                      // R9
   AST_MISALIGN_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (!mem_wr_en && !mem_rd_en));                      // R4
   AST_READ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> load_valid);                                       // R5
   AST_RESULT_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(mem_rd_en));                                // R5
   AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !load_valid |-> (load_data == '0));                              // R5
endmodule

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_op = '0;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_store_data = '0;
   logic [29:0] mem_addr;
   logic        mem_wr_en, mem_rd_en;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        misaligned, load_valid;
   logic [31:0] load_data;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lsu_lane_unit u_lsu_lane_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_base(req_base), .req_offset(req_offset), .req_store_data(req_store_data),
      .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .misaligned(misaligned), .load_valid(load_valid), .load_data(load_data)
   );

   logic [31:0] bmem [16];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) bmem[i] <= '0;
         mem_rdata <= '0;
      end else begin
         if (mem_wr_en)
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) bmem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
         if (mem_rd_en) mem_rdata <= bmem[mem_addr[3:0]];
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_store(input logic [5:0] op, input logic [31:0] base,
                           input logic [15:0] off, input logic [31:0] data,
                           input logic [29:0] exp_addr, input logic [3:0] exp_be,
                           input logic [31:0] exp_wd);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
      req_store_data = data;
      #1;
      check(mem_wr_en && !mem_rd_en && !misaligned, "R3", "store strobe",
            {29'b0, mem_wr_en, mem_rd_en, misaligned}, 32'h4);
      check(mem_addr == exp_addr, "R1", "word address", {2'b0, mem_addr}, {2'b0, exp_addr});
      check(mem_be == exp_be, "R2", "byte enables", {28'b0, mem_be}, {28'b0, exp_be});
      check(mem_wdata == exp_wd, "R3", "lane data", mem_wdata, exp_wd);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_load(input logic [5:0] op, input logic [31:0] base,
                          input logic [15:0] off, input logic [31:0] exp,
                          input string req);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
      #1;
      check(mem_rd_en && !mem_wr_en, "R5", "read strobe",
            {30'b0, mem_rd_en, mem_wr_en}, 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(load_valid, "R5", "load_valid after read", {31'b0, load_valid}, 32'h1);
      check(load_data == exp, req, "load result", load_data, exp);
   endtask

   task automatic do_reject(input logic [5:0] op, input logic [31:0] base,
                            input logic [15:0] off, input bit exp_mis, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
      req_store_data = 32'h1111_1111;
      #1;
      check(misaligned == exp_mis, req, "misaligned flag", {31'b0, misaligned}, {31'b0, exp_mis});
      check(!mem_wr_en && !mem_rd_en && mem_be == 4'h0, req, "no access",
            {26'b0, mem_wr_en, mem_rd_en, mem_be}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check(!load_valid && load_data == 32'h0, req, "no result follows",
            load_data, 32'h0);
   endtask

   task automatic t_reset;
      #1;
      check(!load_valid && load_data == 32'h0 && !mem_wr_en && !mem_rd_en, "R5",
            "reset state", {load_data[29:0], load_valid, mem_wr_en}, 32'h0);
   endtask

   task automatic t_word_le;
      do_store(6'h2B, 32'h0, 16'h0008, 32'h0000_0005, 30'd2, 4'hF, 32'h0000_0005);
      do_load(6'h24, 32'h0, 16'h0008, 32'h0000_0005, "R8");   // R8 low lane at addr 8
      do_load(6'h20, 32'h0, 16'h000B, 32'h0000_0000, "R8");   // R8 top lane zero
      @(negedge clk); #1;
      check(!load_valid && load_data == 32'h0, "R5", "idle data zero", load_data, 32'h0);
   endtask

   task automatic t_byte;
      do_store(6'h28, 32'h0, 16'h0002, 32'hAABB_CC85, 30'd0, 4'h4, 32'h0085_0000);
      do_load(6'h20, 32'h0, 16'h0002, 32'hFFFF_FF85, "R6");
      do_load(6'h24, 32'h0, 16'h0002, 32'h0000_0085, "R7");
   endtask

   task automatic t_half;
      do_store(6'h29, 32'h4, 16'h0002, 32'h7777_8001, 30'd1, 4'hC, 32'h8001_0000);
      do_load(6'h21, 32'h4, 16'h0002, 32'hFFFF_8001, "R6");
      do_load(6'h25, 32'h4, 16'h0002, 32'h0000_8001, "R7");
      do_load(6'h24, 32'h4, 16'h0003, 32'h0000_0080, "R8");
      do_load(6'h20, 32'h4, 16'h0000, 32'h0000_0000, "R8");
   endtask

   task automatic t_negative;
      do_store(6'h2B, 32'h20, 16'hFFF8, 32'hDEAD_BEEF, 30'd6, 4'hF, 32'hDEAD_BEEF); // R1
      do_load(6'h23, 32'h18, 16'h0000, 32'hDEAD_BEEF, "R7");
      do_load(6'h21, 32'h18, 16'h0002, 32'hFFFF_DEAD, "R8");
      do_load(6'h20, 32'h1C, 16'hFFFD, 32'hFFFF_FFBE, "R1");
      do_load(6'h24, 32'h18, 16'h0003, 32'h0000_00DE, "R8");
      do_load(6'h25, 32'h18, 16'h0000, 32'h0000_BEEF, "R7");
   endtask

   task automatic t_misaligned;
      do_reject(6'h29, 32'h18, 16'h0001, 1'b1, "R4");
      do_reject(6'h2B, 32'h18, 16'h0002, 1'b1, "R4");
      do_reject(6'h23, 32'h18, 16'h0001, 1'b1, "R4");
      do_reject(6'h21, 32'h18, 16'h0003, 1'b1, "R4");
      do_load(6'h23, 32'h18, 16'h0000, 32'hDEAD_BEEF, "R4");   // R4 word untouched
      do_store(6'h28, 32'h18, 16'h0003, 32'h0000_0042, 30'd6, 4'h8, 32'h4200_0000);
      do_load(6'h23, 32'h18, 16'h0000, 32'h42AD_BEEF, "R3");
   endtask

   task automatic t_unknown;
      do_reject(6'h2A, 32'h18, 16'h0000, 1'b0, "R9");
      do_reject(6'h22, 32'h18, 16'h0000, 1'b0, "R9");
      do_load(6'h23, 32'h18, 16'h0000, 32'h42AD_BEEF, "R9");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_word_le();
      t_byte();
      t_half();
      t_negative();
      t_misaligned();
      t_unknown();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule